// File: doc/BRIEF.md
# Audio Converter Clock Enable Tree

This block derives every internal timing reference of an audio converter from one master clock. All logic stays on the master clock, and each derived "clock" is a clock-enable strobe one master cycle wide. A one-bit select runs the system rate either at the full master rate or at half of it. A master system enable stops that system rate entirely. A second enable stops only the branch that feeds the signal-processing core and the converters, while peripheral logic keeps its system strobe.

Two programmable dividers sit on the gated branch. Each takes a 3-bit code and counts system strobes. The DAC strobe is the divider output itself. The ADC strobe passes through a fixed halving stage after its divider, so that a divider set to 256 times the sample rate drives the ADC at 128 times the sample rate. A running flag tells control logic whether the system strobe is live, because register access depends on it.

Top module: `audio_clk_tree`

The system path is a four-state machine: `SYS_STOP` (no strobes), `SYS_FULL` (strobe every cycle), `SYS_HALF_WAIT` (no strobe in this cycle) and `SYS_HALF_FIRE` (strobe in this cycle). The machine evaluates these transitions at every edge, in order of priority:
- to `SYS_STOP` when the system enable is low;
- to `SYS_FULL` when the half-rate select is 0;
- from `SYS_HALF_WAIT` to `SYS_HALF_FIRE`;
- from any other state to `SYS_HALF_WAIT`.

Reset enters `SYS_STOP`. The enable and select inputs have no state of their own. Their intended power-on levels are: system enable 1, core enable 1, half select 0.

## Requirements
- R1: With half select (`sys_half_i`) 0, `sys_ce_o` is high in every cycle after the first edge that follows reset release. With it at 1, `sys_ce_o` is high only in even cycles 2, 4, 6, … after reset release, and a strobe is never followed directly by another.
- R2: With `sys_en_i` low at an edge, every strobe output is low in the following cycle. Both dividers keep their counts and resume from those counts.
- R3: With `core_en_i` low, `adc_ce_o` and `dac_ce_o` are low in that same cycle. `sys_ce_o` is unaffected. Both divider counts hold.
- R4: `sys_run_o` is 0 in reset, and after each edge it equals the value `sys_en_i` had at that edge.
- R5: The divider codes give these ratios in system strobes: 000→1, 001→1, 010→2, 011→3, 100→4, 101→6, 110→8, 111→12. The same table serves both dividers.
- R6: `dac_ce_o` is high on every D-th gated system strobe, counted from reset, where D is the ratio of `dac_code_i`.
- R7: `adc_ce_o` is high on every 2·D-th gated system strobe, counted from reset, where D is the ratio of `adc_code_i`.
- R8: A divider reads its code only while its count is zero. A change in the middle of a period lets the old period finish, and the new ratio applies from the next period.
- R9: While reset is held, all outputs are 0, and counting restarts from zero after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | asynchronous active-low reset |
| sys_half_i | input | 1 | 0: system rate equals master rate, 1: half rate |
| sys_en_i | input | 1 | enables the whole system strobe |
| core_en_i | input | 1 | enables the processing/converter branch |
| adc_code_i | input | 3 | ADC divider code (R5) |
| dac_code_i | input | 3 | DAC divider code (R5) |
| sys_ce_o | output | 1 | system clock-enable strobe |
| adc_ce_o | output | 1 | ADC clock-enable strobe |
| dac_ce_o | output | 1 | DAC clock-enable strobe |
| sys_run_o | output | 1 | system strobe is running |

## Verification
The system strobe and the running flag move one edge after `sys_en_i` or `sys_half_i` is sampled. The converter strobes are combinational from registered counts and `core_en_i`, so they respond to the core enable within the same cycle. A divider strobe appears in the cycle of its D-th (or 2·D-th) counted system strobe. The bench drives every input at the falling edge. It samples at the next falling edge, which is cycle n counted from reset release. The expected value for cycle n is computed from the cycle index and a running count of expected gated strobes.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        SYS_STOP,
        SYS_FULL,
        SYS_HALF_WAIT,
        SYS_HALF_FIRE
    } sys_state_e;

    // ratio in system strobes for each divider code
    function automatic int unsigned div_period(input logic [CODE_W-1:0] code);
        int unsigned r;
        case (code)
            3'd0:    r = 1;
            3'd1:    r = 1;
            3'd2:    r = 2;
            3'd3:    r = 3;
            3'd4:    r = 4;
            3'd5:    r = 6;
            3'd6:    r = 8;
            default: r = 12;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clk_sys_fsm.sv
module clk_sys_fsm
    import audio_clk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic half_i,
    output logic ce_o,
    output logic run_o
);

    sys_state_e state_q, state_d;

    always_comb begin
        if (!en_i) begin
            state_d = SYS_STOP;
        end else if (!half_i) begin
            state_d = SYS_FULL;
        end else if (state_q == SYS_HALF_WAIT) begin
            state_d = SYS_HALF_FIRE;
        end else begin
            state_d = SYS_HALF_WAIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SYS_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            SYS_STOP:      begin ce_o = 1'b0; run_o = 1'b0; end
            SYS_FULL:      begin ce_o = 1'b1; run_o = 1'b1; end
            SYS_HALF_WAIT: begin ce_o = 1'b0; run_o = 1'b1; end
            SYS_HALF_FIRE: begin ce_o = 1'b1; run_o = 1'b1; end
            default:       begin ce_o = 1'b0; run_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/clk_div_unit.sv
module clk_div_unit
    import audio_clk_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter bit HALVE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              ce_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] per_eff;
    logic             at_start;
    logic             term;

    assign at_start = (cnt_q == '0);
    // the code is only taken while the count sits at zero
    assign per_eff  = at_start ? CNT_W'(div_period(code_i)) : per_q;
    assign term     = tick_i && (cnt_q == (per_eff - CNT_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            per_q <= CNT_W'(1);
        end else begin
            if (at_start) begin
                per_q <= per_eff;
            end
            if (tick_i) begin
                cnt_q <= term ? '0 : cnt_q + CNT_W'(1);
            end
        end
    end

    generate
        if (HALVE) begin : g_halve
            logic half_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    half_q <= 1'b0;
                end else if (term) begin
                    half_q <= ~half_q;
                end
            end
            assign ce_o = term && half_q;
        end else begin : g_direct
            assign ce_o = term;
        end
    endgenerate

endmodule

// File: rtl/audio_clk_tree.sv
module audio_clk_tree
    import audio_clk_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_half_i,
    input  logic              sys_en_i,
    input  logic              core_en_i,
    input  logic [CODE_W-1:0] adc_code_i,
    input  logic [CODE_W-1:0] dac_code_i,
    output logic              sys_ce_o,
    output logic              adc_ce_o,
    output logic              dac_ce_o,
    output logic              sys_run_o
);

    logic sys_ce;
    logic core_tick;

    clk_sys_fsm u_sys (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (sys_en_i),
        .half_i (sys_half_i),
        .ce_o   (sys_ce),
        .run_o  (sys_run_o)
    );

    assign core_tick = sys_ce && core_en_i;

    clk_div_unit #(.CNT_W(CNT_W), .HALVE(1'b1)) u_adc_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (core_tick),
        .code_i (adc_code_i),
        .ce_o   (adc_ce_o)
    );

    clk_div_unit #(.CNT_W(CNT_W), .HALVE(1'b0)) u_dac_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (core_tick),
        .code_i (dac_code_i),
        .ce_o   (dac_ce_o)
    );

    assign sys_ce_o = sys_ce;

endmodule

// File: rtl/audio_clk_chk.sv
module audio_clk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sys_half_i,
    input logic       sys_en_i,
    input logic       core_en_i,
    input logic [2:0] adc_code_i,
    input logic [2:0] dac_code_i,
    input logic       sys_ce_o,
    input logic       adc_ce_o,
    input logic       dac_ce_o,
    input logic       sys_run_o
);

    p_full_rate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sys_en_i && !sys_half_i |=> sys_ce_o);

    p_half_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sys_half_i && sys_ce_o |=> !sys_ce_o);

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_run_o |-> !(sys_ce_o || adc_ce_o || dac_ce_o));

    p_core_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en_i |-> !(adc_ce_o || dac_ce_o));

    p_run_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_en_i |=> sys_run_o);

    p_run_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_en_i |=> !sys_run_o);

    p_dac_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dac_ce_o |-> sys_ce_o);

    p_adc_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        adc_ce_o |-> sys_ce_o);

endmodule

bind audio_clk_tree audio_clk_chk u_chk (.*);

// File: tb/tb_audio_clk_tree.sv
module tb_audio_clk_tree;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_half_i = 1'b0;
    logic       sys_en_i = 1'b1;
    logic       core_en_i = 1'b1;
    logic [2:0] adc_code_i = 3'd0;
    logic [2:0] dac_code_i = 3'd0;
    logic       sys_ce_o, adc_ce_o, dac_ce_o, sys_run_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_clk_tree dut (.*);

    function automatic int ratio(input int code);
        case (code)
            0, 1:    return 1;
            2:       return 2;
            3:       return 3;
            4:       return 4;
            5:       return 6;
            6:       return 8;
            default: return 12;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // hold reset, check the reset state (R9), then release at a falling edge
    task automatic do_reset(input bit half, input int ac, input int dc);
        rst_n = 1'b0;
        sys_half_i = half; sys_en_i = 1'b1; core_en_i = 1'b1;
        adc_code_i = 3'(ac); dac_code_i = 3'(dc);
        repeat (3) @(negedge clk);
        check(!sys_ce_o && !adc_ce_o && !dac_ce_o && !sys_run_o, "R9 reset outputs",
              {sys_ce_o, adc_ce_o, dac_ce_o, sys_run_o}, 0);
        rst_n = 1'b1;
    endtask

    // core gated in cycles clo..chi, system gated in cycles slo..shi
    task automatic run_cfg(input bit half, input int ac, input int dc,
                           input int clo, input int chi, input int slo, input int shi,
                           input int ncyc);
        int k = 0;
        int m_sys = 0, m_adc = 0, m_dac = 0, m_run = 0;
        int da = ratio(ac);
        int dd = ratio(dc);
        do_reset(half, ac, dc);
        core_en_i = !(1 >= clo && 1 <= chi);
        for (int n = 1; n <= ncyc; n++) begin
            bit e_run, e_sys, e_tick, e_adc, e_dac;
            @(negedge clk);
            e_run = !(n >= slo && n <= shi);
            e_sys = e_run && (half ? (n >= 2 && n % 2 == 0) : 1'b1);
            e_tick = e_sys && !(n >= clo && n <= chi);
            if (e_tick) k++;
            e_dac = e_tick && (k % dd == 0);
            e_adc = e_tick && (k % (2 * da) == 0);
            if (sys_ce_o !== e_sys) m_sys++;
            if (adc_ce_o !== e_adc) m_adc++;
            if (dac_ce_o !== e_dac) m_dac++;
            if (sys_run_o !== e_run) m_run++;
            core_en_i = !(n + 1 >= clo && n + 1 <= chi);
            sys_en_i  = !(n + 1 >= slo && n + 1 <= shi);
        end
        check(m_sys == 0, $sformatf("R1/R2 sys strobe half=%0d", half), m_sys, 0);
        check(m_adc == 0, $sformatf("R7/R5 adc strobe code=%0d", ac), m_adc, 0);
        check(m_dac == 0, $sformatf("R6/R5 dac strobe code=%0d", dc), m_dac, 0);
        check(m_run == 0, "R4 run flag", m_run, 0);
        core_en_i = 1'b1; sys_en_i = 1'b1;
    endtask

    initial begin
        // sweep every code on both dividers at both system rates
        for (int h = 0; h < 2; h++) begin
            for (int c = 0; c < 8; c++) begin
                run_cfg(h[0], c, (c + 3) % 8, -1, -2, -1, -2, 120);
            end
        end
        // R3: core branch gated in cycles 3..7, counts hold
        run_cfg(1'b0, 1, 4, 3, 7, -1, -2, 30);
        run_cfg(1'b1, 2, 5, 4, 11, -1, -2, 60);
        // R2: system gated in cycles 4..8, counts hold
        run_cfg(1'b0, 2, 4, -1, -2, 4, 8, 30);
        // R8: DAC code 4 changed to 2 after cycle 2: strobes at 4, 6, 8, 10
        begin
            int bad = 0;
            do_reset(1'b0, 0, 4);
            for (int n = 1; n <= 10; n++) begin
                bit e;
                @(negedge clk);
                e = (n == 4 || n == 6 || n == 8 || n == 10);
                if (dac_ce_o !== e) bad++;
                if (n == 2) dac_code_i = 3'd2;
            end
            check(bad == 0, "R8 code change at period start", bad, 0);
        end
        // R8: DAC code 6 changed to 0 after cycle 3: strobes at 8, 9, 10
        begin
            int bad = 0;
            do_reset(1'b0, 0, 6);
            for (int n = 1; n <= 10; n++) begin
                bit e;
                @(negedge clk);
                e = (n >= 8);
                if (dac_ce_o !== e) bad++;
                if (n == 3) dac_code_i = 3'd0;
            end
            check(bad == 0, "R8 shrink waits for period end", bad, 0);
        end
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            report();
            $finish;
        end
    end

endmodule